// File: doc/BRIEF.md
# Branch condition evaluator

This block decides whether a conditional branch is taken. It reads a 3-bit condition code, which is the low three bits of the instruction word. It tests that code against the zero and sign status of one general register value. The result is stored in a one-bit condition flop that software cannot see.

The sequencer uses it in two steps. In the first step it raises the load strobe, and the flop captures the decision. In the next step it raises the branch-step strobe. The block then asserts the program-counter load enable only if the stored bit is set, and presents the branch target register value as the new program-counter value.

Register file access and instruction fetch are handled outside this block.

Top module: `branch_cond_unit`

## Requirements
- R1: Code 3'd0 never takes the branch: a load with this code leaves the condition bit at 0 after the edge.
- R2: Code 3'd1 always takes the branch: a load sets the condition bit to 1, whatever the test value is.
- R3: Code 3'd2 takes the branch only when every bit of the test value is 0.
- R4: Code 3'd3 takes the branch only when at least one bit of the test value is 1.
- R5: Code 3'd4 takes the branch when the most significant bit (bit 31) of the test value is 0.
- R6: Code 3'd5 takes the branch when the most significant bit (bit 31) of the test value is 1.
- R7: Codes 3'd6 and 3'd7 are reserved and always evaluate to not taken.
- R8: The condition bit changes only on a rising clock edge while the load strobe is high. In that case it takes the decision for the code and value present at that edge. With the load strobe low it holds its value.
- R9: An active-low asynchronous reset clears the condition bit to 0 immediately.
- R10: The PC load enable is high exactly when the branch-step strobe is high and the stored condition bit is 1. The code and test value present in the same cycle have no direct effect on it.
- R11: Whenever the PC load enable is high, the PC value output equals the branch target input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_code_i | input | 3 | Condition code, the instruction's low three bits |
| test_val_i | input | 32 | Register value that the condition tests |
| cond_load_i | input | 1 | Load strobe for the condition bit |
| branch_step_i | input | 1 | Strobe for the step that may update the PC |
| target_i | input | 32 | Branch target register value |
| cond_q_o | output | 1 | Stored condition bit |
| pc_load_o | output | 1 | PC load enable |
| pc_value_o | output | 32 | Value to load into the PC |

## Verification
The hardest case to reach is a branch step in which the live code and test value disagree with the stored decision. The PC load must follow the latched bit and not the current inputs.

The stimulus covers this in two ways:
- It loads a taken condition, then raises the branch step while presenting a never-taken code and a value that would fail.
- It does the reverse: it loads a not-taken condition, then steps while presenting the always code.

It also changes the code and value over several cycles with the load strobe low, to show that the bit holds. Finally, it drops reset in the middle of a run with the bit set.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    BC_NEVER   = 3'd0,
    BC_ALWAYS  = 3'd1,
    BC_ZERO    = 3'd2,
    BC_NONZERO = 3'd3,
    BC_POS     = 3'd4,
    BC_NEG     = 3'd5,
    BC_RSV6    = 3'd6,
    BC_RSV7    = 3'd7
  } brc_code_e;

  typedef struct packed {
    logic is_zero;
    logic is_neg;
  } brc_status_t;
endpackage

// File: rtl/brc_status.sv
module brc_status
  import brc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output brc_status_t       status_o
);
  localparam int unsigned N_CHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W   = N_CHUNK * CHUNK_W;

  logic [PAD_W-1:0]   padded;
  logic [N_CHUNK-1:0] chunk_any;

  assign padded = PAD_W'(val_i);

  // two-level OR tree for zero detect
  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*CHUNK_W +: CHUNK_W];
  end

  assign status_o.is_zero = ~|chunk_any;
  assign status_o.is_neg  = val_i[DATA_W-1];
endmodule

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  brc_code_e   code_i,
  input  brc_status_t status_i,
  output logic        take_o
);
  always_comb begin
    case (code_i)
      BC_NEVER:   take_o = 1'b0;
      BC_ALWAYS:  take_o = 1'b1;
      BC_ZERO:    take_o = status_i.is_zero;
      BC_NONZERO: take_o = ~status_i.is_zero;
      BC_POS:     take_o = ~status_i.is_neg;
      BC_NEG:     take_o = status_i.is_neg;
      default:    take_o = 1'b0; // reserved codes
    endcase
  end
endmodule

// File: rtl/brc_flag.sv
module brc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i));
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_r9: assert (q_o == 1'b0);
  end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import brc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cond_code_i,
  input  logic [DATA_W-1:0] test_val_i,
  input  logic              cond_load_i,
  input  logic              branch_step_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              cond_q_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_value_o
);
  brc_status_t status;
  logic        take;

  brc_status #(.DATA_W(DATA_W), .CHUNK_W(8)) u_status (
    .val_i    (test_val_i),
    .status_o (status)
  );

  brc_decode u_decode (
    .code_i   (brc_code_e'(cond_code_i)),
    .status_i (status),
    .take_o   (take)
  );

  brc_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cond_load_i),
    .d_i    (take),
    .q_o    (cond_q_o)
  );

  assign pc_load_o  = branch_step_i & cond_q_o;
  assign pc_value_o = target_i;

  p_never_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i == 3'd0 |=> !cond_q_o);
  p_always_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i == 3'd1 |=> cond_q_o);
  p_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i == 3'd2 |=> cond_q_o == ($past(test_val_i) == '0));
  p_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i == 3'd3 |=> cond_q_o == ($past(test_val_i) != '0));
  p_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i == 3'd4 |=> cond_q_o == !$past(test_val_i[DATA_W-1]));
  p_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i == 3'd5 |=> cond_q_o == $past(test_val_i[DATA_W-1]));
  p_rsv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_load_i && cond_code_i[2:1] == 2'b11 |=> !cond_q_o);
  p_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> branch_step_i && cond_q_o);
endmodule

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
  typedef struct {
    bit          q;
    bit          pcl;
    logic [31:0] tgt;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic [2:0]  code = 0;
  logic [31:0] val = 0;
  logic        ld = 0;
  logic        st = 0;
  logic [31:0] tgt = 0;
  logic        cond_q, pc_load;
  logic [31:0] pc_value;

  int     n_chk = 0;
  int     n_bad = 0;
  bit     model_q = 0;
  item_t  sb[$];

  always #10 clk = ~clk;

  branch_cond_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .cond_code_i(code), .test_val_i(val),
    .cond_load_i(ld), .branch_step_i(st), .target_i(tgt),
    .cond_q_o(cond_q), .pc_load_o(pc_load), .pc_value_o(pc_value)
  );

  function automatic bit exp_cond(input logic [2:0] c, input logic [31:0] v);
    case (c)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return v == 32'd0;
      3'd3: return v != 32'd0;
      3'd4: return !v[31];
      3'd5: return v[31];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [2:0] c, input logic [31:0] v, input bit l,
                       input bit s, input logic [31:0] t, input string tag);
    item_t it;
    @(negedge clk);
    code = c; val = v; ld = l; st = s; tgt = t;
    if (l) model_q = exp_cond(c, v);
    it.q = model_q; it.pcl = s && model_q; it.tgt = t; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic check_now(input bit exp_q, input string tag);
    n_chk++;
    if (cond_q !== exp_q || pc_load !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: cond_q=%b pc_load=%b expected %b/0", tag, cond_q, pc_load, exp_q);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (cond_q !== it.q || pc_load !== it.pcl || (it.pcl && pc_value !== it.tgt)) begin
          n_bad++;
          $display("FAIL %s: q=%b pcl=%b pc=%h expected q=%b pcl=%b pc=%h",
                   it.tag, cond_q, pc_load, pc_value, it.q, it.pcl, it.tgt);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'h8000_0000;
    pats[3] = 32'h7fff_ffff; pats[4] = 32'hffff_ffff;

    st = 1;
    #5 check_now(1'b0, "R9 reset");
    repeat (2) @(posedge clk);
    #3 check_now(1'b0, "R9 reset held");
    @(negedge clk); rst_ni = 1; st = 0;

    // every code against every pattern: load, then branch step (R10, R11)
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 5; p++) begin
        drive(3'(c), pats[p], 1'b1, 1'b0, 32'h0, tag_of(3'(c)));
        drive(3'(c), pats[p], 1'b0, 1'b1, 32'h1000 + 32'(c*16 + p), "R10 R11 step");
      end
    end

    // R10: step follows the latched bit, not live inputs
    drive(3'd1, 32'h5, 1'b1, 1'b0, 32'h0, "R2");
    drive(3'd0, 32'h5, 1'b0, 1'b1, 32'hdead_0000, "R10 stale true");
    drive(3'd0, 32'h0, 1'b1, 1'b0, 32'h0, "R1");
    drive(3'd1, 32'h0, 1'b0, 1'b1, 32'hbeef_0000, "R10 stale false");

    // R8: hold with load low while code/value change
    drive(3'd2, 32'h0, 1'b1, 1'b0, 32'h0, "R3");
    drive(3'd0, 32'h0, 1'b0, 1'b0, 32'h0, "R8 hold");
    drive(3'd3, 32'h0, 1'b0, 1'b0, 32'h0, "R8 hold");
    drive(3'd6, 32'h1, 1'b0, 1'b1, 32'h2222, "R8 hold step");
    // load and step in the same cycle: step sees the updated bit
    drive(3'd5, 32'h8000_0000, 1'b1, 1'b1, 32'h3333, "R8 R10 same cycle");
    drive(3'd4, 32'h8000_0000, 1'b1, 1'b1, 32'h4444, "R5 same cycle");
    drive(3'd1, 32'h0, 1'b1, 1'b0, 32'h0, "R2");

    // mid-run reset with the bit set
    repeat (2) @(posedge clk);
    @(negedge clk);
    ld = 0; st = 0;
    rst_ni = 0;
    #2 check_now(1'b0, "R9 async clear");
    model_q = 0;
    @(negedge clk); rst_ni = 1;
    drive(3'd7, 32'h0, 1'b0, 1'b1, 32'h5555, "R9 after reset");
    drive(3'd7, 32'hffff_ffff, 1'b1, 1'b1, 32'h5555, "R7");

    @(negedge clk); ld = 0; st = 0;
    repeat (2) @(posedge clk);
    #6;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule